// File: doc/BRIEF.md
# Pointer-Addressed Packet Buffer Access Port

This block lets a microcontroller read and write a 1024-byte on-chip packet buffer without ever addressing the buffer directly. The host sees four byte-wide registers: a data register, two pointer registers and a setup register. The pointer registers select a buffer location. Every buffer byte passes through the data register. When the pointer is set up for reading, the addressed byte is fetched into the data register ahead of time, so a host read returns it at once. A host write lands in the data register first and is then committed to the buffer.

With auto-increment enabled, each data access moves the pointer to the next byte, which makes sequential filling or draining of a frame cheap. With auto-increment disabled, the pointer stays where it is, so the host can make out-of-order accesses. The buffer has a single port. A network-side requester competes with the host port for it, and a small arbiter alternates grants between the two. A setup bit stretches every arbitration slot for operation at the highest line rate.

The host access channel uses valid/ready. A request is taken on a rising edge where `host_req_valid` and `host_req_ready` are both high. `host_req_ready` is low for data and pointer registers while a prefetch or write-back is pending, and the host must then hold its request unchanged. The setup register is never back-pressured. On the network side, `net_req` acts as valid and `net_gnt` as ready, and the address, direction and write byte must stay stable until the grant arrives.

Top module: `ptrbuf_port`

## Requirements
- R1: After reset the pointer is 0, the direction is write, auto-increment is off, the slow-arbiter bit is 0, the data register reads 0, and `host_req_ready` is high.
- R2: The host register selects are: 0 for the data register, 1 for the pointer bits [7:0], 2 for the pointer high register and 3 for the setup register. The pointer high register holds the read direction at bit 7 (1 = read), auto-increment at bit 6 and pointer bits [9:8] at bits 1:0. The setup register holds the slow-arbiter bit at bit 0. All other bits read as 0, and every register reads back what was written to it.
- R3: A write to the pointer high register with bit 7 set starts a prefetch. Once ready returns, a data read returns the buffer byte at the pointer.
- R4: With read direction and auto-increment, a data read returns the prefetched byte, advances the pointer by one and prefetches the byte at the new address.
- R5: A data write stores the host byte at the pointer address. With auto-increment on, the pointer advances by one after that write-back.
- R6: With auto-increment off, data reads and writes leave the pointer unchanged, and repeated reads return the same byte. The data register changes only on a host data write or on the completion of a prefetch.
- R7: The pointer wraps from 1023 to 0 when it advances.
- R8: While a prefetch or write-back is pending, `host_req_ready` is low for selects 0, 1 and 2, and a data write always leaves a pending write-back. The setup register stays ready throughout.
- R9: The network requester is served on a cycle where `net_gnt` is high. A write stores `net_wdata` at `net_addr`. A read raises `net_rvalid` in the next cycle, with the byte on `net_rdata`.
- R10: The host port and the network requester are never granted in the same cycle. When both request in a free slot, the one not granted last wins, so a host prefetch waits at most one network slot.
- R11: With the slow bit set, no grant follows any grant for the next SLOW_GAP cycles (2 by default). With the bit clear, a lone requester is granted every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req_valid | input | 1 | Host register access request |
| host_req_ready | output | 1 | Host request can be taken this cycle |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_addr | input | 2 | Register select |
| host_req_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read value of the selected register |
| net_req | input | 1 | Network-side buffer request (valid) |
| net_gnt | output | 1 | Network request served this cycle (ready) |
| net_we | input | 1 | Network access is a write |
| net_addr | input | ADDR_W (10) | Network buffer address |
| net_wdata | input | 8 | Network write byte |
| net_rvalid | output | 1 | Network read data valid |
| net_rdata | output | 8 | Network read byte |

## Verification
The properties assume that the host changes its request only after it has been accepted, and that the network requester holds `net_we` and its address steady while `net_req` waits for `net_gnt`. The slow-gap property also assumes that the setup bit seen at a grant is the one that governs the following slot. The bench drives the host only through a task that presents one request and releases it after the accepting edge. The network side is driven either by a similar task or by a steady request that never changes while it is pending. Setup writes happen only at points where the window being measured has not yet begun.

// File: rtl/ptrbuf_pkg.sv
package ptrbuf_pkg;
  localparam int BYTE_W = 8;
  localparam int PHI_DIR_BIT = 7;
  localparam int PHI_INC_BIT = 6;
  localparam int CFG_SLOW_BIT = 0;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_PLO  = 2'd1,
    REG_PHI  = 2'd2,
    REG_CFG  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_RDREQ = 2'd1,
    SEQ_WRREQ = 2'd2,
    SEQ_FILL  = 2'd3
  } seq_e;
endpackage

// File: rtl/ptrbuf_ram.sv
module ptrbuf_ram #(
  parameter int ADDR_W = 10
) (
  input  logic                             clk,
  input  logic                             en,
  input  logic                             we,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [ptrbuf_pkg::BYTE_W-1:0]    wdata,
  output logic [ptrbuf_pkg::BYTE_W-1:0]    q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ptrbuf_pkg::BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      q <= mem[addr];
    end
  end
endmodule

// File: rtl/ptrbuf_arb.sv
module ptrbuf_arb #(
  parameter int SLOW_GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic h_req,
  input  logic n_req,
  input  logic slow,
  output logic h_gnt,
  output logic n_gnt
);
  localparam int GAP_W = (SLOW_GAP > 0) ? $clog2(SLOW_GAP + 1) : 1;

  logic last_net;
  logic free;

  generate
    if (SLOW_GAP > 0) begin : g_gap
      logic [GAP_W-1:0] gap_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          gap_q <= '0;
        end else if (h_gnt | n_gnt) begin
          gap_q <= slow ? GAP_W'(SLOW_GAP) : '0;
        end else if (gap_q != '0) begin
          gap_q <= gap_q - 1'b1;
        end
      end
      assign free = (gap_q == '0);
    end else begin : g_nogap
      assign free = 1'b1 | slow;
    end
  endgenerate

  assign h_gnt = free & h_req & (~n_req | last_net);
  assign n_gnt = free & n_req & (~h_req | ~last_net);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              last_net <= 1'b1;
    else if (h_gnt | n_gnt)  last_net <= n_gnt;
  end
endmodule

// File: rtl/ptrbuf_host.sv
module ptrbuf_host
  import ptrbuf_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        acc_addr,
  input  logic [BYTE_W-1:0] acc_wdata,
  output logic              acc_ready,
  output logic [BYTE_W-1:0] acc_rdata,
  input  logic              gnt,
  input  logic [BYTE_W-1:0] ram_q,
  output logic              mem_req,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              rd_dir_o,
  output logic              ainc_o,
  output logic              slow_o,
  output logic              busy_o,
  output logic [BYTE_W-1:0] data_o
);
  localparam int HI_W  = ADDR_W - 8;
  localparam int PAD_W = 6 - HI_W;

  seq_e              state;
  logic [ADDR_W-1:0] ptr_q;
  logic              dir_q;
  logic              ainc_q;
  logic              slow_q;
  logic [BYTE_W-1:0] data_q;
  logic              acc;

  assign busy_o    = (state != SEQ_IDLE);
  assign acc_ready = (acc_addr == REG_CFG) | (state == SEQ_IDLE);
  assign acc       = acc_valid & acc_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SEQ_IDLE;
      ptr_q  <= '0;
      dir_q  <= 1'b0;
      ainc_q <= 1'b0;
      slow_q <= 1'b0;
      data_q <= '0;
    end else begin
      case (state)
        SEQ_RDREQ: if (gnt) state <= SEQ_FILL;
        SEQ_WRREQ: if (gnt) begin
          state <= SEQ_IDLE;
          if (ainc_q) ptr_q <= ptr_q + 1'b1;
        end
        SEQ_FILL: begin
          data_q <= ram_q;
          state  <= SEQ_IDLE;
        end
        default: ;
      endcase
      if (acc) begin
        case (reg_sel_e'(acc_addr))
          REG_DATA: begin
            if (acc_write) begin
              data_q <= acc_wdata;
              state  <= SEQ_WRREQ;
            end else if (dir_q && ainc_q) begin
              ptr_q <= ptr_q + 1'b1;
              state <= SEQ_RDREQ;
            end
          end
          REG_PLO: if (acc_write) ptr_q[7:0] <= acc_wdata;
          REG_PHI: if (acc_write) begin
            ptr_q[ADDR_W-1:8] <= acc_wdata[HI_W-1:0];
            dir_q  <= acc_wdata[PHI_DIR_BIT];
            ainc_q <= acc_wdata[PHI_INC_BIT];
            if (acc_wdata[PHI_DIR_BIT]) state <= SEQ_RDREQ;
          end
          default: if (acc_write) slow_q <= acc_wdata[CFG_SLOW_BIT];
        endcase
      end
    end
  end

  always_comb begin
    case (reg_sel_e'(acc_addr))
      REG_DATA: acc_rdata = data_q;
      REG_PLO:  acc_rdata = ptr_q[7:0];
      REG_PHI:  acc_rdata = {dir_q, ainc_q, {PAD_W{1'b0}}, ptr_q[ADDR_W-1:8]};
      default:  acc_rdata = {{(BYTE_W-1){1'b0}}, slow_q};
    endcase
  end

  assign mem_req   = (state == SEQ_RDREQ) | (state == SEQ_WRREQ);
  assign mem_we    = (state == SEQ_WRREQ);
  assign mem_wdata = data_q;
  assign ptr_o     = ptr_q;
  assign rd_dir_o  = dir_q;
  assign ainc_o    = ainc_q;
  assign slow_o    = slow_q;
  assign data_o    = data_q;
endmodule

// File: rtl/ptrbuf_port.sv
module ptrbuf_port
  import ptrbuf_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int SLOW_GAP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req_valid,
  output logic              host_req_ready,
  input  logic              host_req_write,
  input  logic [1:0]        host_req_addr,
  input  logic [7:0]        host_req_wdata,
  output logic [7:0]        host_rdata,
  input  logic              net_req,
  output logic              net_gnt,
  input  logic              net_we,
  input  logic [ADDR_W-1:0] net_addr,
  input  logic [7:0]        net_wdata,
  output logic              net_rvalid,
  output logic [7:0]        net_rdata
);
  logic              h_gnt;
  logic              n_gnt;
  logic              mem_req;
  logic              mem_we;
  logic [BYTE_W-1:0] mem_wdata;
  logic [ADDR_W-1:0] ptr_q;
  logic              rd_dir;
  logic              ainc;
  logic              slow_q;
  logic              host_busy;
  logic [BYTE_W-1:0] data_q;
  logic [BYTE_W-1:0] ram_q;
  logic              ram_en;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [BYTE_W-1:0] ram_wdata;

  ptrbuf_host #(.ADDR_W(ADDR_W)) u_host (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(host_req_valid), .acc_write(host_req_write),
    .acc_addr(host_req_addr), .acc_wdata(host_req_wdata),
    .acc_ready(host_req_ready), .acc_rdata(host_rdata),
    .gnt(h_gnt), .ram_q(ram_q),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .ptr_o(ptr_q), .rd_dir_o(rd_dir), .ainc_o(ainc), .slow_o(slow_q),
    .busy_o(host_busy), .data_o(data_q)
  );

  ptrbuf_arb #(.SLOW_GAP(SLOW_GAP)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .h_req(mem_req), .n_req(net_req), .slow(slow_q),
    .h_gnt(h_gnt), .n_gnt(n_gnt)
  );

  assign ram_en    = h_gnt | n_gnt;
  assign ram_we    = h_gnt ? mem_we : (n_gnt & net_we);
  assign ram_addr  = h_gnt ? ptr_q : net_addr;
  assign ram_wdata = h_gnt ? mem_wdata : net_wdata;

  ptrbuf_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .en(ram_en), .we(ram_we),
    .addr(ram_addr), .wdata(ram_wdata), .q(ram_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) net_rvalid <= 1'b0;
    else        net_rvalid <= n_gnt & ~net_we;
  end

  assign net_gnt   = n_gnt;
  assign net_rdata = ram_q;
endmodule

// File: rtl/ptrbuf_chk.sv
module ptrbuf_chk #(
  parameter int ADDR_W   = 10,
  parameter int SLOW_GAP = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_req_valid,
  input logic              host_req_ready,
  input logic              host_req_write,
  input logic [1:0]        host_req_addr,
  input logic [7:0]        host_req_wdata,
  input logic              net_we,
  input logic              net_rvalid,
  input logic              h_gnt,
  input logic              n_gnt,
  input logic              slow_q,
  input logic              host_busy,
  input logic              rd_dir,
  input logic              ainc,
  input logic [ADDR_W-1:0] ptr_q,
  input logic [7:0]        data_q
);
  logic take;
  assign take = host_req_valid & host_req_ready;

  AST_GNT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_gnt && n_gnt)); // R10

  AST_PREFETCH_START: assert property (@(posedge clk) disable iff (!rst_n)
    (take && host_req_write && host_req_addr == 2'd2 && host_req_wdata[7]) |=> host_busy); // R3

  AST_WRITE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && host_req_write && host_req_addr == 2'd0) |=> host_busy); // R8

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !host_req_write && host_req_addr == 2'd0 && rd_dir && ainc)
      |=> ptr_q == $past(ptr_q) + 1'b1); // R7

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_busy && !(take && host_req_write && host_req_addr == 2'd0)) |=> $stable(data_q)); // R6

  AST_NET_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    net_rvalid |-> ($past(n_gnt) && !$past(net_we))); // R9

  generate
    if (SLOW_GAP > 0) begin : g_slow
      AST_SLOW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_q && (h_gnt || n_gnt)) |=> !(h_gnt || n_gnt)); // R11
    end
  endgenerate
endmodule

bind ptrbuf_port ptrbuf_chk #(.ADDR_W(ADDR_W), .SLOW_GAP(SLOW_GAP)) u_chk (.*);

// File: tb/ptrbuf_port_bench.sv
module ptrbuf_port_bench;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_req_valid = 1'b0;
  logic host_req_ready;
  logic host_req_write = 1'b0;
  logic [1:0] host_req_addr = 2'd0;
  logic [7:0] host_req_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic net_req = 1'b0;
  logic net_gnt;
  logic net_we = 1'b0;
  logic [AW-1:0] net_addr = '0;
  logic [7:0] net_wdata = 8'd0;
  logic net_rvalid;
  logic [7:0] net_rdata;

  int checks = 0;
  int failures = 0;
  int ngnt_cnt = 0;
  bit finished = 0;
  logic [7:0] model [DEPTH];

  always #5 clk = ~clk;

  ptrbuf_port u_ptrbuf_port (.*);

  always @(negedge clk) if (net_gnt) ngnt_cnt++;

  function automatic logic [7:0] pat(input int a);
    return 8'(((a * 37) ^ (a >> 3)) + 5);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_acc(input logic wr, input logic [1:0] a, input logic [7:0] d,
                          output logic [7:0] q);
    @(negedge clk);
    host_req_valid = 1'b1; host_req_write = wr; host_req_addr = a; host_req_wdata = d;
    #1;
    while (!host_req_ready) begin @(negedge clk); #1; end
    q = host_rdata;
    @(posedge clk);
    #1 host_req_valid = 1'b0;
  endtask

  task automatic hwr(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] q;
    host_acc(1'b1, a, d, q);
  endtask

  task automatic hrd(input logic [1:0] a, output logic [7:0] q);
    host_acc(1'b0, a, 8'd0, q);
  endtask

  task automatic set_ptr(input int p, input logic rd, input logic inc);
    hwr(2'd1, 8'(p));
    hwr(2'd2, {rd, inc, 4'b0, 2'(p >> 8)});
  endtask

  task automatic busy_len(output int n);
    host_req_addr = 2'd0;
    n = 0;
    forever begin
      @(negedge clk); #1;
      if (host_req_ready) break;
      n++;
    end
  endtask

  task automatic net_acc(input logic we, input int a, input logic [7:0] d);
    @(negedge clk);
    net_req = 1'b1; net_we = we; net_addr = AW'(a); net_wdata = d;
    #1;
    while (!net_gnt) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 net_req = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    #1 chk("R1 ready", host_req_ready, 1);
    hrd(2'd0, q); chk("R1 data", q, 0);
    hrd(2'd1, q); chk("R1 ptr lo", q, 0);
    hrd(2'd2, q); chk("R1 ptr hi", q, 0);
    hrd(2'd3, q); chk("R1 setup", q, 0);

    // R2 register map readback
    hwr(2'd1, 8'h5A); hwr(2'd2, 8'h7F);
    hrd(2'd1, q); chk("R2 ptr lo", q, 8'h5A);
    hrd(2'd2, q); chk("R2 ptr hi", q, 8'h43);
    hwr(2'd3, 8'hFF); hrd(2'd3, q); chk("R2 setup", q, 8'h01);
    hwr(2'd3, 8'h00);

    // R5 auto-increment write sweep over the whole buffer
    set_ptr(0, 1'b0, 1'b1);
    for (int a = 0; a < DEPTH; a++) begin
      hwr(2'd0, pat(a)); model[a] = pat(a);
    end
    hrd(2'd1, q); chk("R7 wrap lo after writes", q, 0);
    hrd(2'd2, q); chk("R7 wrap hi after writes", q, 8'h40);

    // R3 R4 prefetch + auto-increment read sweep
    set_ptr(0, 1'b1, 1'b1);
    for (int a = 0; a < DEPTH; a++) begin
      hrd(2'd0, q); chk($sformatf("R4 read %0d", a), q, model[a]);
    end
    hrd(2'd1, q); chk("R7 wrap lo after reads", q, 0);
    hrd(2'd0, q); chk("R7 byte 0 after wrap", q, model[0]);

    // R3 prefetch at an arbitrary address
    set_ptr(16'h2E7, 1'b1, 1'b0);
    hrd(2'd0, q); chk("R3 prefetch 2E7", q, model[16'h2E7]);

    // R6 fixed pointer reads and writes
    set_ptr(16'h133, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      hrd(2'd0, q); chk("R6 repeat read", q, model[16'h133]);
    end
    hrd(2'd1, q); chk("R6 ptr held after reads", q, 8'h33);
    set_ptr(16'h133, 1'b0, 1'b0);
    hwr(2'd0, 8'hA5); hwr(2'd0, 8'h5B); model[16'h133] = 8'h5B;
    hrd(2'd1, q); chk("R6 ptr held after writes", q, 8'h33);
    set_ptr(16'h133, 1'b1, 1'b0);
    hrd(2'd0, q); chk("R5 fixed write stored", q, 8'h5B);
    set_ptr(16'h134, 1'b1, 1'b0);
    hrd(2'd0, q); chk("R6 neighbour untouched", q, model[16'h134]);

    // R8 back-pressure while write-back pending
    set_ptr(16'h201, 1'b0, 1'b0);
    hwr(2'd0, 8'h3C); model[16'h201] = 8'h3C;
    #1 host_req_addr = 2'd0; #1 chk("R8 data blocked", host_req_ready, 0);
    host_req_addr = 2'd1; #1 chk("R8 ptr blocked", host_req_ready, 0);
    host_req_addr = 2'd3; #1 chk("R8 setup open", host_req_ready, 1);

    // R9 network write then host read, and network read of host byte
    net_acc(1'b1, 16'h200, 8'h77); model[16'h200] = 8'h77;
    set_ptr(16'h200, 1'b1, 1'b0);
    hrd(2'd0, q); chk("R9 net write seen by host", q, 8'h77);
    net_acc(1'b0, 16'h201, 8'h00);
    @(negedge clk);
    chk("R9 rvalid", net_rvalid, 1);
    chk("R9 rdata", net_rdata, 8'h3C);
    @(negedge clk);
    chk("R9 rvalid single", net_rvalid, 0);

    // R10 contention with a network requester holding the bus
    net_we = 1'b0; net_addr = AW'(5); net_req = 1'b1;
    set_ptr(16'h10, 1'b1, 1'b1);
    busy_len(n); chk("R10 prefetch latency fast", n <= 2, 1);
    for (int i = 0; i < 8; i++) begin
      hrd(2'd0, q); chk("R10 read under contention", q, model[16'h10 + i]);
    end
    hwr(2'd3, 8'h01);
    set_ptr(16'h40, 1'b1, 1'b1);
    busy_len(n); chk("R11 prefetch latency slow", n <= 4, 1);
    for (int i = 0; i < 8; i++) begin
      hrd(2'd0, q); chk("R11 read slow contention", q, model[16'h40 + i]);
    end
    busy_len(n);
    repeat (4) @(negedge clk);
    #1 ngnt_cnt = 0;
    repeat (21) @(negedge clk);
    #1 chk("R11 slow grant rate", ngnt_cnt, 7);
    hwr(2'd3, 8'h00);
    repeat (3) @(negedge clk);
    #1 ngnt_cnt = 0;
    repeat (20) @(negedge clk);
    #1 chk("R11 fast grant rate", ngnt_cnt, 20);
    net_req = 1'b0;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule